// File: doc/BRIEF.md
# Shared Ready/Data Serial Output

This block drives one output pin that serves two purposes. Once a new conversion word has been captured into its output register, the pin drops low for a fixed number of system clocks to announce that a result is waiting. After that strobe the same pin carries the word itself, most significant bit first, and an external reader steps it forward one bit per rising edge of its serial clock. When no strobe and no readout is under way, the pin rests high.

Words arrive on a valid/ready stream input. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops once the reader has taken the first serial edge of a word, and it stays low until the last bit has gone out. A producer that offers a word during that time must hold `in_valid` high and `in_data` unchanged until the word is taken. A new conversion is therefore deferred, and the word on the pin is never disturbed. A separate `settled` level from the upstream filter says whether an offered word is fully settled. Unsettled words are still captured, but they produce neither a strobe nor a readout. As a result, the first strobe after reset marks the first valid result.

Top module: `shared_rdy_dout`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rdy_dout_n` is 1 and `in_ready` is 1.
- R2: A word taken while `settled` is 1 drives `rdy_dout_n` to 0 from the next cycle for exactly PULSE_LEN cycles (default 4).
- R3: A word taken while `settled` is 0 leaves `rdy_dout_n` at 1 on the next cycle and starts no readout. No strobe ever appears before a settled word is taken.
- R4: When the strobe ends, the pin shows bit 23 of the word. Each rising edge of `sclk` advances it to the next lower bit, so the word is delivered MSB-first as 24 bits.
- R5: The rising `sclk` edge that moves past bit 0 returns `rdy_dout_n` to 1.
- R6: `in_ready` is 0 from the first `sclk` rising edge of a readout until the rising edge that moves past bit 0. A word offered in that window is taken on the first cycle after the readout ends.
- R7: `sclk` edges while the pin is idle or strobing have no effect on the pin or on the word that is read out later.
- R8: A word taken after a strobe but before the first `sclk` rising edge replaces the pending word and restarts the strobe.
- R9: Apart from a strobe or a readout, `rdy_dout_n` rests at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| settled | input | 1 | Upstream filter reports a fully settled result |
| in_valid | input | 1 | Conversion word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 24 | Conversion word |
| sclk | input | 1 | Reader's serial clock, sampled by clk |
| rdy_dout_n | output | 1 | Shared pin: low strobe for ready, then serial data |

## Verification
A wrong internal state shows at the pin almost at once. If the bit counter is off, the bit sequence has the wrong length or the wrong order within one word. If the strobe timer is miscounted, the low strobe is too long or too short. If the arming or back-pressure state is wrong, `in_ready` changes on the wrong cycle or a word is taken in the middle of a readout. The bench models the block from its requirements and compares both outputs on every cycle, so any such fault is reported on the first cycle where the pin or `in_ready` differs.

// File: rtl/shared_rdy_dout_pkg.sv
package shared_rdy_dout_pkg;
  localparam int unsigned WORD_W_DEF = 24;
  localparam int unsigned PULSE_LEN_DEF = 4;

  typedef enum logic [1:0] {
    PIN_IDLE  = 2'd0,
    PIN_READY = 2'd1,
    PIN_DATA  = 2'd2
  } pin_mode_e;
endpackage

// File: rtl/sdo_edge_detect.sv
module sdo_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/sdo_pulse_timer.sv
module sdo_pulse_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic active,
  output logic done
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (cancel) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign done = active && (cnt == LAST);
endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] data,
  input  logic         arm,
  input  logic         step,
  output logic         bit_out,
  output logic         armed,
  output logic         busy
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  word;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      armed <= 1'b0;
      cnt   <= '0;
    end else if (capture) begin
      word  <= data;
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (step && armed) begin
      word <= {word[W-2:0], 1'b0};
      if (cnt == LAST) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign bit_out = word[W-1];
  assign busy    = armed && (cnt != '0);
endmodule

// File: rtl/shared_rdy_dout.sv
module shared_rdy_dout
  import shared_rdy_dout_pkg::*;
#(
  parameter int unsigned WORD_W    = WORD_W_DEF,
  parameter int unsigned PULSE_LEN = PULSE_LEN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              settled,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              sclk,
  output logic              rdy_dout_n
);
  logic      accept;
  logic      sclk_rise;
  logic      pulse_active;
  logic      pulse_done;
  logic      armed;
  logic      busy;
  logic      bit_out;
  pin_mode_e mode;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  sdo_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (sclk),
    .rise   (sclk_rise)
  );

  sdo_pulse_timer #(.LEN(PULSE_LEN)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept & settled),
    .cancel (accept & ~settled),
    .active (pulse_active),
    .done   (pulse_done)
  );

  sdo_shifter #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .data    (in_data),
    .arm     (pulse_done & ~accept),
    .step    (sclk_rise),
    .bit_out (bit_out),
    .armed   (armed),
    .busy    (busy)
  );

  always_comb begin
    if (pulse_active) mode = PIN_READY;
    else if (armed)   mode = PIN_DATA;
    else              mode = PIN_IDLE;
  end

  always_comb begin
    unique case (mode)
      PIN_READY: rdy_dout_n = 1'b0;
      PIN_DATA:  rdy_dout_n = bit_out;
      default:   rdy_dout_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/shared_rdy_dout_checker.sv
module shared_rdy_dout_checker #(
  parameter int unsigned PULSE_LEN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic settled,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic rdy_dout_n,
  input logic pulse_active,
  input logic armed
);
  logic        sclk_seen;
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_seen <= 1'b0;
      low_run   <= '0;
    end else begin
      sclk_seen <= sclk;
      low_run   <= pulse_active ? low_run + 1'b1 : '0;
    end
  end

  // R2: strobe never lasts longer than PULSE_LEN cycles
  p_pulse_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active |-> (low_run < 16'(PULSE_LEN)));

  // R2: settled word starts a low strobe on the next cycle
  p_strobe_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && settled) |=> !rdy_dout_n);

  // R3: unsettled word leaves the pin high and no readout armed
  p_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !settled) |=> (rdy_dout_n && !armed));

  // R6: back-pressure only ends on a serial clock rising edge
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !(sclk && !sclk_seen)) |=> !in_ready);

  // R7: strobe and readout never overlap
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_active && armed));
endmodule

bind shared_rdy_dout shared_rdy_dout_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .settled      (settled),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .sclk         (sclk),
  .rdy_dout_n   (rdy_dout_n),
  .pulse_active (pulse_active),
  .armed        (armed)
);

// File: tb/shared_rdy_dout_test.sv
`timescale 1ns/1ps
module shared_rdy_dout_test;
  localparam int W  = 24;
  localparam int PL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          settled = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic          sclk = 1'b0;
  logic          rdy_dout_n;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int           m_mode = 0;   // 0 idle, 1 strobe, 2 data
  int           m_pc = 0;
  int           m_idx = 0;
  logic [W-1:0] m_word = '0;
  bit           m_prev = 0;

  shared_rdy_dout #(.WORD_W(W), .PULSE_LEN(PL)) uut (
    .clk(clk), .rst_n(rst_n), .settled(settled), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .sclk(sclk), .rdy_dout_n(rdy_dout_n)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  function automatic logic m_pin();
    if (m_mode == 1) return 1'b0;
    if (m_mode == 2) return m_word[W-1-m_idx];
    return 1'b1;
  endfunction

  function automatic logic m_ready();
    return !(m_mode == 2 && m_idx > 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pc = 0; m_idx = 0; m_word = '0; m_prev = 0;
    end else begin
      bit rise;
      bit acc;
      rise = sclk && !m_prev;
      m_prev = sclk;
      acc = in_valid && m_ready();
      if (acc) begin
        m_word = in_data; m_idx = 0; m_pc = 0;
        m_mode = settled ? 1 : 0;
      end else if (m_mode == 1) begin
        if (m_pc == PL - 1) begin m_mode = 2; m_idx = 0; end
        else m_pc++;
      end else if (m_mode == 2 && rise) begin
        if (m_idx == W - 1) begin m_mode = 0; m_idx = 0; end
        else m_idx++;
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(m_mode == 1 ? "R2 pin" : (m_mode == 2 ? "R4 pin" : "R9 pin"), rdy_dout_n, m_pin());
      check("R6 in_ready", in_ready, m_ready());
    end
  end

  task automatic offer(input logic [W-1:0] d, input logic s);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; settled = s;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_bits(input int n, output logic [W-1:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got = {got[W-2:0], rdy_dout_n};
      sclk = 1'b1;
      @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic wait_strobe();
    repeat (PL + 1) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] got;
    int lows;
    #1;
    check("R1 pin in reset", rdy_dout_n, 1'b1);
    check("R1 ready in reset", in_ready, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin after reset", rdy_dout_n, 1'b1);
    check("R1 ready after reset", in_ready, 1'b1);

    // R3: unsettled words give no strobe
    offer(24'hA5A5A5, 1'b0);
    check("R3 no strobe", rdy_dout_n, 1'b1);
    offer(24'h123456, 1'b0);
    repeat (PL + 2) begin @(negedge clk); check("R3 stays high", rdy_dout_n, 1'b1); end

    // R2: strobe length, R4 word read, R5 back high
    @(negedge clk);
    in_valid = 1'b1; in_data = 24'hC3_5A_F1; settled = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lows = 0;
    while (rdy_dout_n == 1'b0 && lows < 20) begin lows++; @(negedge clk); end
    check("R2 strobe length", lows == PL, 1'b1);
    read_bits(W, got);
    check("R4 word C35AF1", got == 24'hC35AF1, 1'b1);
    @(negedge clk);
    check("R5 high after word", rdy_dout_n, 1'b1);

    // R7: sclk during idle and strobe is ignored
    repeat (3) begin @(negedge clk); sclk = 1'b1; @(negedge clk); sclk = 1'b0; end
    check("R7 idle ignore", rdy_dout_n, 1'b1);
    @(negedge clk);
    in_valid = 1'b1; in_data = 24'h0F_0F_0F; settled = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    read_bits(W, got);
    check("R7 word intact", got == 24'h0F0F0F, 1'b1);

    // R8: replacement before the first serial edge
    offer(24'h111111, 1'b1);
    wait_strobe();
    offer(24'hFEDCBA, 1'b1);
    wait_strobe();
    read_bits(W, got);
    check("R8 replaced word", got == 24'hFEDCBA, 1'b1);

    // R6: deferral of a word offered mid-readout
    offer(24'h800001, 1'b1);
    wait_strobe();
    read_bits(5, got);
    @(negedge clk);
    in_valid = 1'b1; in_data = 24'h7E57AB; settled = 1'b1;
    check("R6 busy mid-word", in_ready, 1'b0);
    read_bits(W - 5, got);
    check("R6 tail of word", got[W-6:0] == 19'h00001, 1'b1);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 deferred strobe", rdy_dout_n, 1'b0);
    repeat (PL) @(negedge clk);
    read_bits(W, got);
    check("R6 deferred word", got == 24'h7E57AB, 1'b1);
    @(negedge clk);
    check("R9 rest high", rdy_dout_n, 1'b1);

    // R3: unsettled word offered while armed cancels readout
    offer(24'h00FF00, 1'b1);
    wait_strobe();
    offer(24'h00FF00, 1'b0);
    check("R3 unsettled cancels", rdy_dout_n, 1'b1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule